// File: doc/BRIEF.md
# Open-Bus Peripheral Access Bridge

The bridge sits between the data port of a 32-bit processor and a small set of peripheral register slaves. Each slave has its own natural width and its own rule for narrow stores. One slave is a word-wide scratch store that merges narrow data. One is a 32-bit control register that takes any store as a full word, zero-extended. One is a 16-bit timer mode register whose status bits 11 and 12 clear when the processor reads it. A fourth slot is unmapped.

Instruction fetches and data accesses share one bus, so the bridge keeps a 32-bit latch of the last value on each byte lane. When a slave drives only some lanes of a read, or drives none, the other lanes return the latched bytes. Narrow stores to merging slaves run as a read-modify-write. The internal read for the merge is kept apart from a real processor read, so it never clears the timer status bits. It also never touches the bus latch.

A four-state machine controls each request. IDLE accepts a request when `req_valid` is high, with `req_ready` high only in IDLE. From IDLE, a narrow store to a merging slot goes to MRG_RD and any other request goes to ACCESS. ACCESS performs the read or the full write and returns to IDLE. MRG_RD captures the merge word and always moves to MRG_WR. MRG_WR writes the merged word and returns to IDLE.

Top module: `obus_bridge`

## Requirements
- R1: After reset the bus latch, the scratch store, the control register and the timer mode register are all zero, `rsp_valid` is low and `req_ready` is high.
- R2: Address bits 5:4 select the slot: 0 scratch store (word index from bits 3:2), 1 control register, 2 timer mode register, 3 unmapped. Size code 00 is byte, 01 halfword, 10 word, and 11 acts as word. A word store to the scratch store is returned unchanged by a later word load.
- R3: A halfword store to a merging slot writes data bits 15:0 into bits 15:0 when address bit 1 is 0, or into bits 31:16 when it is 1, and keeps the other half.
- R4: A byte store to a merging slot writes data bits 7:0 into the lane chosen by address bits 1:0 and keeps the other three lanes.
- R5: Any narrow store to the control register writes the whole register: a byte goes to bits 7:0 and clears bits 31:8, and a halfword goes to bits 15:0 and clears bits 31:16.
- R6: A word load from the timer slot returns the mode register in bits 15:0 and the latched bus bits in bits 31:16, which equal the upper half of the last fetched instruction when nothing else has driven those lanes since.
- R7: A load from the unmapped slot returns the whole latch.
- R8: The latch loads all four lanes from a fetch. On a load it loads the lanes the slave drives (all four for the scratch store and control register, lanes 1:0 for the timer). On a store it loads the lanes the processor drives (the addressed lanes for a merging narrow store, all four otherwise). A fetch wins over a data access in the same cycle.
- R9: A processor load from the timer slot returns bits 12:11 as they were, then clears them. A flag pulse on `tmr_flag_set` sets them and wins over a clear in the same cycle. Stores never change bits 12:11.
- R10: A narrow store to the timer slot leaves bits 12:11 set. The merge read has no side effect on the timer and leaves the latch unchanged.
- R11: `rsp_valid` is a one-cycle pulse, two clock edges after acceptance for a load or a full store, and three for a merged narrow store. `req_ready` is low while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and accepting |
| req_addr | input | 32 | Byte address |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_wdata | input | 32 | Store data, right-aligned |
| fetch_valid | input | 1 | An instruction fetch drives the bus this cycle |
| fetch_data | input | 32 | Fetched instruction word |
| tmr_flag_set | input | 2 | Sets timer mode bits 11 (bit 0) and 12 (bit 1) |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Load data (zero for stores) |

## Verification
The bench aims at the lane-merge edge cases. It tests halfword and byte stores at every address offset, where a wrong lane select would corrupt the neighbouring bytes. It tests zero-extending stores at odd addresses, where a design that merged would leave stale upper bits. It loads the timer and the unmapped slot right after a fetch, so that a design which zero-fills undriven lanes returns zero where the latched instruction bits belong. It sets the timer status bits and then stores a byte to the timer, so that a merge read wrongly treated as a processor read would clear them. A random mix of fetches, flag pulses and accesses across all slots, sizes and offsets then tracks the latch through long histories.

// File: rtl/obus_pkg.sv
package obus_pkg;

    localparam int DW    = 32;
    localparam int LANES = DW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic {
        POL_MERGE = 1'b0,
        POL_ZEXT  = 1'b1
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACCESS = 2'b01,
        ST_MRG_RD = 2'b10,
        ST_MRG_WR = 2'b11
    } state_e;

    localparam logic [1:0] SLOT_RAM  = 2'd0;
    localparam logic [1:0] SLOT_CTRL = 2'd1;
    localparam logic [1:0] SLOT_TMR  = 2'd2;
    localparam logic [1:0] SLOT_NONE = 2'd3;

    function automatic policy_e slot_policy(input logic [1:0] slot);
        unique case (slot)
            SLOT_RAM:  return POL_MERGE;
            SLOT_TMR:  return POL_MERGE;
            default:   return POL_ZEXT;
        endcase
    endfunction

    function automatic logic [LANES-1:0] slot_lanes(input logic [1:0] slot);
        unique case (slot)
            SLOT_RAM:  return 4'b1111;
            SLOT_CTRL: return 4'b1111;
            SLOT_TMR:  return 4'b0011;
            default:   return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/obus_lane_ctl.sv
module obus_lane_ctl
    import obus_pkg::*;
(
    input  size_e            size,
    input  logic [1:0]       addr_lo,
    input  policy_e          pol,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    merge_word,
    output logic [DW-1:0]    write_word,
    output logic [DW-1:0]    bus_word,
    output logic [LANES-1:0] drive_mask
);

    logic [LANES-1:0] be;
    logic [DW-1:0]    placed;
    logic [DW-1:0]    zext;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be     = 4'b0001 << addr_lo;
                placed = {LANES{wdata[7:0]}};
                zext   = {24'h0, wdata[7:0]};
            end
            SZ_HALF: begin
                be     = addr_lo[1] ? 4'b1100 : 4'b0011;
                placed = {2{wdata[15:0]}};
                zext   = {16'h0, wdata[15:0]};
            end
            default: begin
                be     = 4'b1111;
                placed = wdata;
                zext   = wdata;
            end
        endcase
    end

    always_comb begin
        if (pol == POL_MERGE) begin
            for (int l = 0; l < LANES; l++) begin
                write_word[8*l +: 8] = be[l] ? placed[8*l +: 8] : merge_word[8*l +: 8];
            end
            bus_word   = placed;
            drive_mask = be;
        end else begin
            write_word = zext;
            bus_word   = zext;
            drive_mask = '1;
        end
    end

endmodule

// File: rtl/obus_bus_latch.sv
module obus_bus_latch
    import obus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [DW-1:0]    fetch_data,
    input  logic [LANES-1:0] drv_mask,
    input  logic [DW-1:0]    drv_data,
    output logic [DW-1:0]    q
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[8*l +: 8] <= '0;
            end else if (fetch_valid) begin
                q[8*l +: 8] <= fetch_data[8*l +: 8];
            end else if (drv_mask[l]) begin
                q[8*l +: 8] <= drv_data[8*l +: 8];
            end
        end
    end

endmodule

// File: rtl/obus_ram_slave.sv
module obus_ram_slave
    import obus_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (we && (idx == IW'(w))) begin
                mem[w] <= wdata;
            end
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/obus_timer_slave.sv
module obus_timer_slave (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    input  logic        rd_clr,
    input  logic [1:0]  flag_set,
    output logic [15:0] mode
);

    logic [15:0] mode_d;

    always_comb begin
        mode_d = mode;
        if (we) begin
            mode_d = {wdata[15:13], mode[12:11], wdata[10:0]};
        end
        if (rd_clr) begin
            mode_d[12:11] = 2'b00;
        end
        mode_d[12:11] = mode_d[12:11] | flag_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else begin
            mode <= mode_d;
        end
    end

endmodule

// File: rtl/obus_bridge.sv
module obus_bridge
    import obus_pkg::*;
#(
    parameter int RAM_WORDS = 4,
    localparam int RIW      = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        req_we,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_data,
    input  logic [1:0]  tmr_flag_set,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);

    state_e           state_q, state_d;
    logic [31:0]      r_addr;
    logic             r_we;
    size_e            r_size;
    logic [DW-1:0]    r_wdata;
    logic [DW-1:0]    merge_q;

    logic [1:0]       slot;
    policy_e          pol;
    logic [LANES-1:0] rd_lanes;
    logic [DW-1:0]    slave_word;
    logic [DW-1:0]    rd_word;
    logic [DW-1:0]    latch_q;
    logic [DW-1:0]    ram_rdata;
    logic [DW-1:0]    ctrl_q;
    logic [15:0]      tmr_q;

    logic [DW-1:0]    wr_word;
    logic [DW-1:0]    wr_bus;
    logic [LANES-1:0] wr_mask;

    logic             cpu_rd;
    logic             wr_strobe;
    logic             tmr_rd_clr;
    logic             unmapped_rd;
    logic             req_narrow_merge;
    logic [LANES-1:0] lat_mask;
    logic [DW-1:0]    lat_data;

    assign slot     = r_addr[5:4];
    assign pol      = slot_policy(slot);
    assign rd_lanes = slot_lanes(slot);

    assign req_narrow_merge = req_we
                           && ((req_size == SZ_BYTE) || (req_size == SZ_HALF))
                           && (slot_policy(req_addr[5:4]) == POL_MERGE);

    // Read qualifier: only a processor load in ACCESS may cause side effects
    assign cpu_rd      = (state_q == ST_ACCESS) && !r_we;
    assign wr_strobe   = ((state_q == ST_ACCESS) && r_we) || (state_q == ST_MRG_WR);
    assign tmr_rd_clr  = cpu_rd && (slot == SLOT_TMR);
    assign unmapped_rd = cpu_rd && (slot == SLOT_NONE);
    assign req_ready   = (state_q == ST_IDLE);

    always_comb begin
        unique case (slot)
            SLOT_RAM:  slave_word = ram_rdata;
            SLOT_CTRL: slave_word = ctrl_q;
            SLOT_TMR:  slave_word = {16'h0, tmr_q};
            default:   slave_word = '0;
        endcase
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_word[8*l +: 8] = rd_lanes[l] ? slave_word[8*l +: 8] : latch_q[8*l +: 8];
        end
    end

    obus_lane_ctl u_lane (
        .size       (r_size),
        .addr_lo    (r_addr[1:0]),
        .pol        (pol),
        .wdata      (r_wdata),
        .merge_word (merge_q),
        .write_word (wr_word),
        .bus_word   (wr_bus),
        .drive_mask (wr_mask)
    );

    always_comb begin
        lat_mask = '0;
        lat_data = wr_bus;
        if (cpu_rd) begin
            lat_mask = rd_lanes;
            lat_data = slave_word;
        end else if (wr_strobe) begin
            lat_mask = wr_mask;
            lat_data = wr_bus;
        end
    end

    obus_bus_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .drv_mask    (lat_mask),
        .drv_data    (lat_data),
        .q           (latch_q)
    );

    obus_ram_slave #(.WORDS(RAM_WORDS)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_strobe && (slot == SLOT_RAM)),
        .idx   (r_addr[2 +: RIW]),
        .wdata (wr_word),
        .rdata (ram_rdata)
    );

    obus_timer_slave u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_strobe && (slot == SLOT_TMR)),
        .wdata    (wr_word[15:0]),
        .rd_clr   (tmr_rd_clr),
        .flag_set (tmr_flag_set),
        .mode     (tmr_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_strobe && (slot == SLOT_CTRL)) begin
            ctrl_q <= wr_word;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = req_narrow_merge ? ST_MRG_RD : ST_ACCESS;
            ST_ACCESS: state_d = ST_IDLE;
            ST_MRG_RD: state_d = ST_MRG_WR;
            ST_MRG_WR: state_d = ST_IDLE;
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            r_addr  <= '0;
            r_we    <= 1'b0;
            r_size  <= SZ_WORD;
            r_wdata <= '0;
            merge_q <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && req_valid) begin
                r_addr  <= req_addr;
                r_we    <= req_we;
                r_size  <= size_e'(req_size);
                r_wdata <= req_wdata;
            end
            if (state_q == ST_MRG_RD) begin
                merge_q <= rd_word;
            end
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state_q == ST_ACCESS) || (state_q == ST_MRG_WR);
            rsp_rdata <= cpu_rd ? rd_word : '0;
        end
    end

endmodule

// File: rtl/obus_bridge_chk.sv
module obus_bridge_chk
    import obus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rsp_valid,
    input  logic        req_ready,
    input  state_e      state,
    input  logic [31:0] latch,
    input  logic [15:0] tmr_mode,
    input  logic        tmr_rd_clr,
    input  logic        unmapped_rd,
    input  logic        fetch_valid,
    input  logic [31:0] rsp_rdata
);

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R9
    tmr_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_mode[11]) |-> $past(tmr_rd_clr));

    // R9
    tmr_clr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_mode[12]) |-> $past(tmr_rd_clr));

    // R10
    mrg_rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MRG_RD && !fetch_valid) |=> $stable(latch));

    // R7
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_rd |=> (rsp_rdata == $past(latch)));

endmodule

bind obus_bridge obus_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid   (rsp_valid),
    .req_ready   (req_ready),
    .state       (state_q),
    .latch       (latch_q),
    .tmr_mode    (tmr_q),
    .tmr_rd_clr  (tmr_rd_clr),
    .unmapped_rd (unmapped_rd),
    .fetch_valid (fetch_valid),
    .rsp_rdata   (rsp_rdata)
);

// File: tb/obus_bridge_tb.sv
`timescale 1ns/1ps
module obus_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_data = '0;
    logic [1:0]  tmr_flag_set = 2'b00;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] m_ram [4];
    logic [31:0] m_ctrl;
    logic [15:0] m_tmr;
    logic [31:0] m_lat;

    always #2.5 clk = ~clk;

    obus_bridge dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_we       (req_we),
        .req_size     (req_size),
        .req_wdata    (req_wdata),
        .fetch_valid  (fetch_valid),
        .fetch_data   (fetch_data),
        .tmr_flag_set (tmr_flag_set),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slave_of(input logic [31:0] a);
        case (a[5:4])
            2'd0:    return m_ram[a[3:2]];
            2'd1:    return m_ctrl;
            2'd2:    return {16'h0, m_tmr};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] lanes_of(input logic [1:0] s);
        case (s)
            2'd0, 2'd1: return 4'b1111;
            2'd2:       return 4'b0011;
            default:    return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] lane_mix(input logic [3:0] m, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[8*l +: 8] = m[l] ? a[8*l +: 8] : b[8*l +: 8];
        return r;
    endfunction

    task automatic op(input logic [31:0] addr, input logic we, input logic [1:0] sz,
                      input logic [31:0] wd, input string tag);
        logic [31:0] exp_rd, w, place;
        logic [3:0]  be, drive;
        int          lat, cnt;
        bit          merging, narrow, early_ok;
        merging = (addr[5:4] == 2'd0) || (addr[5:4] == 2'd2);
        narrow  = (sz == 2'b00) || (sz == 2'b01);
        exp_rd  = 32'h0;
        lat     = (we && merging && narrow) ? 3 : 2;
        if (!we) begin
            exp_rd = lane_mix(lanes_of(addr[5:4]), slave_of(addr), m_lat);
            m_lat  = exp_rd;
            if (addr[5:4] == 2'd2) m_tmr[12:11] = 2'b00;
        end else begin
            if (!narrow) begin
                w = wd; place = wd; drive = 4'b1111;
            end else if (merging) begin
                be    = (sz == 2'b00) ? (4'b0001 << addr[1:0]) : (addr[1] ? 4'b1100 : 4'b0011);
                place = (sz == 2'b00) ? {4{wd[7:0]}} : {2{wd[15:0]}};
                w     = lane_mix(be, place, lane_mix(lanes_of(addr[5:4]), slave_of(addr), m_lat));
                drive = be;
            end else begin
                w = (sz == 2'b00) ? {24'h0, wd[7:0]} : {16'h0, wd[15:0]};
                place = w; drive = 4'b1111;
            end
            case (addr[5:4])
                2'd0: m_ram[addr[3:2]] = w;
                2'd1: m_ctrl = w;
                2'd2: m_tmr = {w[15:13], m_tmr[12:11], w[10:0]};
                default: ;
            endcase
            m_lat = lane_mix(drive, place, m_lat);
        end
        @(negedge clk);
        chk(req_ready === 1'b1, "R11 ready when idle", {31'h0, req_ready}, 32'h1);
        req_valid = 1'b1; req_addr = addr; req_we = we; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        early_ok = (req_ready === 1'b0);
        cnt = 1;
        while (rsp_valid !== 1'b1 && cnt < 10) begin
            @(negedge clk);
            cnt++;
        end
        chk(early_ok && cnt == lat, "R11 latency/busy", cnt, lat);
        if (!we) chk(rsp_rdata === exp_rd, tag, rsp_rdata, exp_rd);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11 single pulse", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic fetch(input logic [31:0] d);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_data = d;
        @(negedge clk);
        fetch_valid = 1'b0;
        m_lat = d;
    endtask

    task automatic flags(input logic [1:0] f);
        @(negedge clk);
        tmr_flag_set = f;
        @(negedge clk);
        tmr_flag_set = 2'b00;
        m_tmr[12:11] = m_tmr[12:11] | f;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0b5e_0a1d));
        for (int i = 0; i < 4; i++) m_ram[i] = '0;
        m_ctrl = '0; m_tmr = '0; m_lat = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 reset outputs",
            {30'h0, rsp_valid, req_ready}, 32'h1);
        op(32'h30, 0, 2'b10, 0, "R1 latch zero");
        op(32'h04, 0, 2'b10, 0, "R1 ram zero");
        op(32'h20, 0, 2'b10, 0, "R1 timer zero");
        op(32'h10, 0, 2'b10, 0, "R1 ctrl zero");

        op(32'h04, 1, 2'b10, 32'hCAFE_F00D, "R2");
        op(32'h04, 0, 2'b10, 0, "R2 word readback");
        op(32'h0C, 1, 2'b11, 32'h1357_9BDF, "R2");
        op(32'h0C, 0, 2'b10, 0, "R2 size 11 as word");

        op(32'h00, 1, 2'b10, 32'h1111_2222, "R3");
        op(32'h00, 1, 2'b01, 32'h0000_AAAA, "R3");
        op(32'h00, 0, 2'b10, 0, "R3 low half");
        op(32'h02, 1, 2'b01, 32'hFFFF_BBBB, "R3");
        op(32'h00, 0, 2'b10, 0, "R3 high half");

        op(32'h08, 1, 2'b10, 32'h0, "R4");
        for (int b = 0; b < 4; b++) begin
            op(32'h08 + b, 1, 2'b00, 32'hFFFF_FF10 + b, "R4");
            op(32'h08, 0, 2'b10, 0, "R4 byte lane");
        end

        op(32'h10, 1, 2'b10, 32'hFFFF_FFFF, "R5");
        op(32'h13, 1, 2'b00, 32'h1234_56AB, "R5");
        op(32'h10, 0, 2'b10, 0, "R5 byte zero-extend");
        op(32'h12, 1, 2'b01, 32'h9876_C0DE, "R5");
        op(32'h10, 0, 2'b10, 0, "R5 half zero-extend");

        op(32'h20, 1, 2'b10, 32'h0000_0155, "R6");
        fetch(32'hDEAD_1234);
        op(32'h20, 0, 2'b10, 0, "R6 upper from fetch");
        fetch(32'h8C42_0010);
        op(32'h30, 0, 2'b10, 0, "R7 unmapped returns latch");
        op(32'h24, 0, 2'b10, 0, "R8 timer load keeps latch upper");
        op(32'h30, 0, 2'b10, 0, "R8 latch lanes after timer load");
        op(32'h01, 1, 2'b00, 32'h0000_0077, "R8");
        op(32'h30, 0, 2'b10, 0, "R8 latch after byte store");

        flags(2'b11);
        op(32'h20, 0, 2'b10, 0, "R9 flags visible");
        op(32'h20, 0, 2'b10, 0, "R9 flags cleared by load");
        flags(2'b10);
        op(32'h20, 1, 2'b10, 32'h0000_0000, "R9");
        op(32'h20, 0, 2'b10, 0, "R9 store keeps flag");

        flags(2'b11);
        op(32'h21, 1, 2'b00, 32'h0000_00E4, "R10");
        op(32'h22, 1, 2'b01, 32'h0000_5A5A, "R10");
        op(32'h20, 1, 2'b01, 32'h0000_0003, "R10");
        op(32'h20, 0, 2'b10, 0, "R10 flags kept by merge");

        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom % 10;
            if (r == 0) fetch($urandom);
            else if (r == 1) flags(2'($urandom));
            else op({26'h0, 6'($urandom)}, 1'($urandom), 2'($urandom), $urandom, "R8 random load");
        end
        for (int s = 0; s < 4; s++) op(32'(s * 16), 0, 2'b10, 0, "R8 final sweep");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule